// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a lane group are enabled while the group runs one shared instruction stream through structured control flow. It holds one activity bit per lane as the top entry of a small stack of masks. Three structured commands change that mask:

- An if command pushes a narrower mask, built from a per-lane condition vector.
- An else command swaps the top entry over to the lanes that took the other branch.
- An endif command drops the top entry and returns to the enclosing mask.

The execution pipeline uses the active mask to gate write-back. A lane whose bit is clear has its instruction discarded. A skip hint tells the sequencer when no lane is active on the current path, so that the body can be jumped over.

The condition vector given with each if is stored next to the pushed mask, so that the matching else can use its complement. Nesting deeper than the stack allows is refused and raises overflow. An else or endif with nothing open is refused and raises underflow. In both cases the state is left unchanged. A synchronous reset loads the lane-valid vector as the outermost mask.

Top module: `simt_div_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the depth becomes 0, the active mask becomes `lane_valid`, and `overflow` and `underflow` become 0.
- R2: `wb_en` equals `active_mask` while `issue` is 1 and is all zeros while `issue` is 0, so an inactive lane never receives a write-back enable.
- R3: An accepted if command (opcode 1) at a depth below `DEPTH` does two things on the next edge: it makes the active mask the previous active mask AND `cmd_cond`, and it raises the depth by one.
- R4: An accepted else command (opcode 2) at a depth above 0 replaces the top entry with the enclosing mask AND the complement of the condition that was stored with the matching if. The depth is left unchanged.
- R5: An accepted endif command (opcode 3) at a depth above 0 lowers the depth by one and restores the enclosing mask.
- R6: `skip` is 1 exactly when the depth is above 0 and the active mask is all zeros.
- R7: An if command at depth `DEPTH` sets `overflow` for one cycle and leaves the mask and depth unchanged.
- R8: An else or endif command at depth 0 sets `underflow` for one cycle and leaves the mask and depth unchanged.
- R9: A cycle with `cmd_valid` low, or with opcode 0 (no-op), changes neither the mask nor the depth, and raises no error flag.
- R10: With 8 lanes at mask 0xFF, the following sequence gives these masks: if 0x03 gives 0x03; if 0x01 gives 0x01; else gives 0x02; endif gives 0x03; endif gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 0 no-op, 1 if, 2 else, 3 endif |
| cmd_cond | input | LANES | Per-lane condition, sampled with an if command |
| lane_valid | input | LANES | Lanes present; loaded as the outer mask at reset |
| issue | input | 1 | An instruction is issued this cycle |
| active_mask | output | LANES | Current activity bits |
| wb_en | output | LANES | Per-lane write-back enable |
| depth | output | $clog2(DEPTH+1) | Number of open if levels |
| skip | output | 1 | No lane active on the current path |
| overflow | output | 1 | Push refused because the stack is full |
| underflow | output | 1 | Else or endif refused because the stack is empty |

## Verification
The hardest state to reach from the ports is an else at full depth: it must read the condition stored at the deepest level, right next to the point where overflow refuses a push. The stimulus opens eight nested ifs with a different condition at each level. It then tries a ninth if, issues an else, and unwinds with endifs down to an underflow. A long stretch of random commands follows, weighted towards if and endif so that the depth wanders over its whole range. A behavioural queue model checks every clock, and a second reset with a different lane-valid vector confirms that the outer mask follows it.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_IF    = 2'd1,
        OP_ELSE  = 2'd2,
        OP_ENDIF = 2'd3
    } div_op_e;
endpackage

// File: rtl/simt_div_decode.sv
module simt_div_decode #(
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cur_depth,
    output logic          do_push,
    output logic          do_else,
    output logic          do_pop,
    output logic          err_ovf,
    output logic          err_unf
);
    import simt_div_pkg::*;

    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    div_op_e op;
    logic    is_full;
    logic    is_empty;

    always_comb begin
        op       = div_op_e'(cmd_op);
        is_full  = (cur_depth == FULL);
        is_empty = (cur_depth == '0);
        do_push  = 1'b0;
        do_else  = 1'b0;
        do_pop   = 1'b0;
        err_ovf  = 1'b0;
        err_unf  = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_IF: begin
                    do_push = !is_full;
                    err_ovf = is_full;
                end
                OP_ELSE: begin
                    do_else = !is_empty;
                    err_unf = is_empty;
                end
                OP_ENDIF: begin
                    do_pop  = !is_empty;
                    err_unf = is_empty;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/simt_div_store.sv
module simt_div_store #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] cmd_cond,
    input  logic             do_push,
    input  logic             do_else,
    input  logic             do_pop,
    input  logic             err_ovf,
    input  logic             err_unf,
    output logic [LANES-1:0] top_mask,
    output logic [DW-1:0]    cur_depth,
    output logic             ovf_q,
    output logic             unf_q
);
    typedef struct packed {
        logic [DEPTH:0][LANES-1:0] masks;
        logic [DEPTH:0][LANES-1:0] conds;
        logic [DW-1:0]             depth;
        logic                      ovf;
        logic                      unf;
    } store_t;

    store_t s_d;
    store_t s_q;
    logic [DW-1:0] up_idx;
    logic [DW-1:0] dn_idx;

    always_comb begin
        s_d     = s_q;
        up_idx  = s_q.depth + 1'b1;
        dn_idx  = s_q.depth - 1'b1;
        s_d.ovf = err_ovf;
        s_d.unf = err_unf;
        if (do_push) begin
            s_d.masks[up_idx] = s_q.masks[s_q.depth] & cmd_cond;
            s_d.conds[up_idx] = cmd_cond;
            s_d.depth         = up_idx;
        end else if (do_else) begin
            s_d.masks[s_q.depth] = s_q.masks[dn_idx] & ~s_q.conds[s_q.depth];
        end else if (do_pop) begin
            s_d.depth = dn_idx;
        end
        if (!rst_n) begin
            s_d          = '0;
            s_d.masks[0] = lane_valid;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign top_mask  = s_q.masks[s_q.depth];
    assign cur_depth = s_q.depth;
    assign ovf_q     = s_q.ovf;
    assign unf_q     = s_q.unf;
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LANES-1:0] cmd_cond,
    input  logic [LANES-1:0] lane_valid,
    input  logic             issue,
    output logic [LANES-1:0] active_mask,
    output logic [LANES-1:0] wb_en,
    output logic [DW-1:0]    depth,
    output logic             skip,
    output logic             overflow,
    output logic             underflow
);
    logic do_push;
    logic do_else;
    logic do_pop;
    logic err_ovf;
    logic err_unf;

    simt_div_decode #(.DEPTH(DEPTH)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cur_depth (depth),
        .do_push   (do_push),
        .do_else   (do_else),
        .do_pop    (do_pop),
        .err_ovf   (err_ovf),
        .err_unf   (err_unf)
    );

    simt_div_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_valid (lane_valid),
        .cmd_cond   (cmd_cond),
        .do_push    (do_push),
        .do_else    (do_else),
        .do_pop     (do_pop),
        .err_ovf    (err_ovf),
        .err_unf    (err_unf),
        .top_mask   (active_mask),
        .cur_depth  (depth),
        .ovf_q      (overflow),
        .unf_q      (underflow)
    );

    always_comb begin
        wb_en = issue ? active_mask : '0;
        skip  = (depth != '0) && (active_mask == '0);
    end
endmodule

// File: rtl/simt_div_stack_chk.sv
module simt_div_stack_chk #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [LANES-1:0] cmd_cond,
    input logic             issue,
    input logic [LANES-1:0] active_mask,
    input logic [LANES-1:0] wb_en,
    input logic [DW-1:0]    depth,
    input logic             overflow,
    input logic             underflow
);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en & ~active_mask) == '0 && (issue || wb_en == '0)); // R2

    AST_IF_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && depth != FULL) |=>
        (depth == $past(depth) + 1'b1) &&
        (active_mask == ($past(active_mask) & $past(cmd_cond)))); // R3

    AST_ENDIF_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3 && depth != '0) |=>
        (depth == $past(depth) - 1'b1)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && depth == FULL) |=>
        overflow && $stable(depth) && $stable(active_mask)); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1] && depth == '0) |=>
        underflow && $stable(depth) && $stable(active_mask)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 2'd0) |=>
        $stable(depth) && $stable(active_mask) && !overflow && !underflow); // R9
endmodule

bind simt_div_stack simt_div_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_cond    (cmd_cond),
    .issue       (issue),
    .active_mask (active_mask),
    .wb_en       (wb_en),
    .depth       (depth),
    .overflow    (overflow),
    .underflow   (underflow)
);

// File: tb/simt_div_stack_tb.sv
module simt_div_stack_tb;
    localparam int LANES = 8;
    localparam int DEPTH = 8;
    localparam int DW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [LANES-1:0] cmd_cond = '0;
    logic [LANES-1:0] lane_valid = 8'h3F;
    logic             issue = 1'b0;
    logic [LANES-1:0] active_mask;
    logic [LANES-1:0] wb_en;
    logic [DW-1:0]    depth;
    logic             skip;
    logic             overflow;
    logic             underflow;

    int n_chk = 0;
    int n_bad = 0;

    logic [LANES-1:0] m_mask[$];
    logic [LANES-1:0] m_cond[$];
    bit               m_ovf;
    bit               m_unf;

    always #4 clk = ~clk;

    simt_div_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cond(cmd_cond), .lane_valid(lane_valid), .issue(issue),
        .active_mask(active_mask), .wb_en(wb_en), .depth(depth),
        .skip(skip), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [LANES-1:0] top;
        int d;
        top = m_mask[$];
        d   = m_mask.size() - 1;
        chk(tag, "mask", int'(active_mask), int'(top));
        chk(tag, "depth", int'(depth), d);
        chk("R6", "skip", int'(skip), int'(d > 0 && top == '0));
        chk(tag, "overflow", int'(overflow), int'(m_ovf));
        chk(tag, "underflow", int'(underflow), int'(m_unf));
        chk("R2", "wb_en", int'(wb_en), issue ? int'(top) : 0);
    endtask

    task automatic model_reset();
        m_mask.delete();
        m_cond.delete();
        m_mask.push_back(lane_valid);
        m_cond.push_back('0);
        m_ovf = 0;
        m_unf = 0;
    endtask

    task automatic model_cmd(bit v, logic [1:0] op, logic [LANES-1:0] c);
        int d;
        d = m_mask.size() - 1;
        m_ovf = 0;
        m_unf = 0;
        if (!v) return;
        case (op)
            2'd1: if (d == DEPTH) m_ovf = 1;
                  else begin
                      m_mask.push_back(m_mask[$] & c);
                      m_cond.push_back(c);
                  end
            2'd2: if (d == 0) m_unf = 1;
                  else m_mask[d] = m_mask[d-1] & ~m_cond[d];
            2'd3: if (d == 0) m_unf = 1;
                  else begin
                      void'(m_mask.pop_back());
                      void'(m_cond.pop_back());
                  end
            default: ;
        endcase
    endtask

    task automatic step(string tag, bit v, logic [1:0] op,
                        logic [LANES-1:0] c, bit iss);
        cmd_valid = v;
        cmd_op    = op;
        cmd_cond  = c;
        issue     = iss;
        @(posedge clk);
        model_cmd(v, op, c);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(logic [LANES-1:0] lv);
        rst_n      = 1'b0;
        lane_valid = lv;
        cmd_valid  = 1'b0;
        issue      = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        model_reset();
        compare("R1");
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        do_reset(8'hFF);
        // R10 nested example
        step("R10", 1, 2'd1, 8'h03, 1);
        step("R10", 1, 2'd1, 8'h01, 1);
        step("R10", 1, 2'd2, 8'h5A, 1);
        step("R10", 1, 2'd3, 8'h00, 0);
        step("R10", 1, 2'd3, 8'h00, 1);
        // R6 uniform not taken, then else makes all active
        step("R6", 1, 2'd1, 8'h00, 1);
        step("R4", 1, 2'd2, 8'h00, 1);
        step("R5", 1, 2'd3, 8'h00, 1);
        // R8 underflow
        step("R8", 1, 2'd2, 8'h00, 0);
        step("R8", 1, 2'd3, 8'h00, 1);
        // R9 idle and no-op
        step("R9", 0, 2'd1, 8'h0F, 0);
        step("R9", 1, 2'd0, 8'h0F, 1);
        // R7 fill to full with distinct conditions
        for (int i = 0; i < DEPTH; i++)
            step("R3", 1, 2'd1, ~(8'h01 << (i % LANES)), 1);
        step("R7", 1, 2'd1, 8'hFF, 1);
        step("R4", 1, 2'd2, 8'h00, 1);
        step("R7", 1, 2'd1, 8'hFF, 0);
        for (int i = 0; i < DEPTH; i++)
            step("R5", 1, 2'd3, 8'h00, 1);
        step("R8", 1, 2'd3, 8'h00, 1);
        // random run
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [1:0] op;
            r  = $urandom_range(0, 9);
            op = (r < 4) ? 2'd1 : (r < 6) ? 2'd2 : (r < 9) ? 2'd3 : 2'd0;
            step("R3", $urandom_range(0, 7) != 0, op, 8'($urandom), 1'($urandom));
        end
        // R1 second reset with another lane-valid pattern
        do_reset(8'hA5);
        step("R3", 1, 2'd1, 8'h0F, 1);
        step("R4", 1, 2'd2, 8'h00, 1);
        step("R5", 1, 2'd3, 8'h00, 1);
        finish_run();
    end
endmodule